// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block holds the register-page selector that a small processor core uses to reach banked special function registers. The selector comes from the top of a three-level stack. When the interrupt controller vectors to a handler, the block looks up the page that this source's handler needs. It places that page on top and moves the older selectors one level deeper, so the handler can reach its own registers with no software action. The oldest value falls off the bottom. A return from interrupt undoes the move. Nested interrupts each push once, so every active handler level keeps its own page.

Software can read and write each level through a slot index. This lets a handler inspect or change the saved pages. An enable input turns the automatic switching off. While it is off, interrupt entry and return leave the stack alone. The per-source page table is a parameter that is fixed at build time.

Top module: `irq_page_stack`

## Requirements
- R1: While `rst` is high, all three levels are cleared to 0x00 at the clock edge.
- R2: When `auto_en` and `irq_take` are high at a clock edge, the top level becomes the table page of `irq_src`. With the default table, source n maps to page n*0x11, so both nibbles equal n.
- R3: On that same push, the old top moves to the middle level and the old middle moves to the bottom level. The old bottom value is discarded, even if software wrote it.
- R4: Back-to-back pushes from different sources nest. After two pushes, the top holds the second source's page and the middle holds the first source's page.
- R5: When `auto_en` and `irq_ret` are high and `irq_take` is low, the middle value moves to the top and the bottom value moves to the middle. The bottom level keeps its value.
- R6: With `auto_en` low, `irq_take` and `irq_ret` change no level.
- R7: When `sw_wr_en` is high, `sw_wdata` is written at the clock edge to the level chosen by `sw_wsel` (0 = top, 1 = middle, 2 = bottom). A select value of 3 writes nothing.
- R8: `sw_rdata` shows, with no clock delay, the level chosen by `sw_rsel` (0 = top, 1 = middle, 2 = bottom). A select value of 3 reads 0x00.
- R9: If a push or a pop happens in the same cycle as a software write, only the push or pop takes effect and the write is discarded.
- R10: If `irq_take` and `irq_ret` are both high with `auto_en` high, the block performs a push.
- R11: `page_sel` always equals the top level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic page switching on interrupt entry and return |
| irq_take | input | 1 | Strobe: an interrupt is being vectored |
| irq_src | input | 4 | Index of the source being vectored |
| irq_ret | input | 1 | Strobe: return from interrupt |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wsel | input | 2 | Level to write: 0 = top, 1 = middle, 2 = bottom |
| sw_wdata | input | 8 | Page value to write |
| sw_rsel | input | 2 | Level to read: 0 = top, 1 = middle, 2 = bottom |
| sw_rdata | output | 8 | Value of the selected level |
| page_sel | output | 8 | Active page selector (the top level) |

## Verification
The stack is first loaded with distinct values by software, so each later shift shows exactly which level moved where. A push that follows a software write to the bottom level shows that the written value is lost. Two nested pushes followed by two pops show that push and pop are inverse operations, and that the bottom level is duplicated upward rather than cleared. Cycles that combine push or pop with a software write, or push with return, or strobes with switching disabled, tell the priority order apart. A push from every one of the sixteen sources checks each entry of the page table.

// File: rtl/ips_pkg.sv
package ips_pkg;

    localparam int PAGE_W  = 8;
    localparam int SRC_W   = 4;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int STACK_D = 3;
    localparam int SEL_W   = $clog2(STACK_D + 1);
    localparam int MAP_W   = NUM_SRC * PAGE_W;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SEL_W-1:0]  slot_t;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_WRITE
    } stk_op_e;

    typedef struct packed {
        slot_t slot;
        page_t data;
    } wr_req_t;

    // Default per-source map: source n selects page n*0x11.
    function automatic logic [MAP_W-1:0] build_page_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            m[k*PAGE_W +: PAGE_W] = page_t'((k * 17) % (1 << PAGE_W));
        end
        return m;
    endfunction

    function automatic logic slot_valid(slot_t s);
        return int'(s) < STACK_D;
    endfunction

endpackage

// File: rtl/ips_page_map.sv
module ips_page_map
    import ips_pkg::*;
#(
    parameter logic [MAP_W-1:0] MAP = build_page_map()
) (
    input  logic [SRC_W-1:0] src,
    output page_t            page
);

    page_t tbl [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_tbl
        assign tbl[g] = MAP[g*PAGE_W +: PAGE_W];
    end

    assign page = tbl[src];

endmodule

// File: rtl/ips_ctrl.sv
module ips_ctrl
    import ips_pkg::*;
(
    input  logic    auto_en,
    input  logic    irq_take,
    input  logic    irq_ret,
    input  logic    sw_wr_en,
    input  slot_t   sw_wsel,
    input  page_t   sw_wdata,
    output stk_op_e op,
    output wr_req_t wr
);

    // Priority: push, then pop, then software write.
    always_comb begin
        wr.slot = sw_wsel;
        wr.data = sw_wdata;
        if (auto_en && irq_take) begin
            op = STK_PUSH;
        end else if (auto_en && irq_ret) begin
            op = STK_POP;
        end else if (sw_wr_en && slot_valid(sw_wsel)) begin
            op = STK_WRITE;
        end else begin
            op = STK_HOLD;
        end
    end

endmodule

// File: rtl/ips_stack.sv
module ips_stack
    import ips_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op,
    input  page_t   new_page,
    input  wr_req_t wr,
    output page_t   ent [STACK_D]
);

    page_t q [STACK_D];

    for (genvar g = 0; g < STACK_D; g++) begin : g_lvl
        page_t from_above;
        page_t from_below;

        if (g == 0) begin : g_top
            assign from_above = new_page;
        end else begin : g_inner
            assign from_above = q[g-1];
        end

        if (g == STACK_D - 1) begin : g_bot
            assign from_below = q[g];
        end else begin : g_upper
            assign from_below = q[g+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else begin
                unique case (op)
                    STK_PUSH:  q[g] <= from_above;
                    STK_POP:   q[g] <= from_below;
                    STK_WRITE: if (wr.slot == slot_t'(g)) q[g] <= wr.data;
                    default:   q[g] <= q[g];
                endcase
            end
        end

        assign ent[g] = q[g];
    end

endmodule

// File: rtl/irq_page_stack.sv
module irq_page_stack
    import ips_pkg::*;
#(
    parameter logic [MAP_W-1:0] PAGE_MAP = build_page_map()
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             irq_take,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             irq_ret,
    input  logic             sw_wr_en,
    input  logic [SEL_W-1:0] sw_wsel,
    input  logic [PAGE_W-1:0] sw_wdata,
    input  logic [SEL_W-1:0] sw_rsel,
    output logic [PAGE_W-1:0] sw_rdata,
    output logic [PAGE_W-1:0] page_sel
);

    page_t   src_page;
    stk_op_e op;
    wr_req_t wr;
    page_t   ent_q [STACK_D];

    ips_page_map #(.MAP(PAGE_MAP)) u_map (
        .src  (irq_src),
        .page (src_page)
    );

    ips_ctrl u_ctrl (
        .auto_en  (auto_en),
        .irq_take (irq_take),
        .irq_ret  (irq_ret),
        .sw_wr_en (sw_wr_en),
        .sw_wsel  (sw_wsel),
        .sw_wdata (sw_wdata),
        .op       (op),
        .wr       (wr)
    );

    ips_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .new_page (src_page),
        .wr       (wr),
        .ent      (ent_q)
    );

    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < STACK_D; i++) begin
            if (sw_rsel == slot_t'(i)) sw_rdata = ent_q[i];
        end
    end

    assign page_sel = ent_q[0];

endmodule

// File: rtl/irq_page_stack_chk.sv
module irq_page_stack_chk
    import ips_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  auto_en,
    input logic  irq_take,
    input logic  irq_ret,
    input logic  sw_wr_en,
    input page_t src_page,
    input page_t page_sel,
    input page_t ent [STACK_D]
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ent[0] == '0 && ent[1] == '0 && ent[2] == '0));

    a_r2_push_top: assert property (@(posedge clk) disable iff (rst)
        (auto_en && irq_take) |=> page_sel == $past(src_page));

    a_r3_push_shift: assert property (@(posedge clk) disable iff (rst)
        (auto_en && irq_take) |=> (ent[1] == $past(ent[0]) && ent[2] == $past(ent[1])));

    a_r5_pop_shift: assert property (@(posedge clk) disable iff (rst)
        (auto_en && irq_ret && !irq_take) |=>
            (ent[0] == $past(ent[1]) && ent[1] == $past(ent[2]) && $stable(ent[2])));

    a_r6_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !sw_wr_en) |=> ($stable(ent[0]) && $stable(ent[1]) && $stable(ent[2])));

endmodule

bind irq_page_stack irq_page_stack_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en),
    .irq_take (irq_take),
    .irq_ret  (irq_ret),
    .sw_wr_en (sw_wr_en),
    .src_page (src_page),
    .page_sel (page_sel),
    .ent      (ent_q)
);

// File: tb/irq_page_stack_tb_top.sv
module irq_page_stack_tb_top;

    typedef struct {
        logic [7:0] top;
        logic [7:0] mid;
        logic [7:0] bot;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_en = 1'b0;
    logic       irq_take = 1'b0;
    logic [3:0] irq_src = '0;
    logic       irq_ret = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [1:0] sw_wsel = '0;
    logic [7:0] sw_wdata = '0;
    logic [1:0] sw_rsel = '0;
    logic [7:0] sw_rdata;
    logic [7:0] page_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb_q[$];
    logic [7:0] m [3] = '{8'h00, 8'h00, 8'h00};

    always #5 clk = ~clk;

    irq_page_stack dut_i (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (auto_en),
        .irq_take (irq_take),
        .irq_src  (irq_src),
        .irq_ret  (irq_ret),
        .sw_wr_en (sw_wr_en),
        .sw_wsel  (sw_wsel),
        .sw_wdata (sw_wdata),
        .sw_rsel  (sw_rsel),
        .sw_rdata (sw_rdata),
        .page_sel (page_sel)
    );

    function automatic logic [7:0] page_of(logic [3:0] s);
        return {s, s};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, update the model, queue expectation.
    task automatic cyc(bit r, bit ae, bit tk, logic [3:0] s, bit rt,
                       bit we, logic [1:0] ws, logic [7:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        rst = r; auto_en = ae; irq_take = tk; irq_src = s; irq_ret = rt;
        sw_wr_en = we; sw_wsel = ws; sw_wdata = wd;
        if (r) begin
            m = '{8'h00, 8'h00, 8'h00};
        end else if (ae && tk) begin
            m[2] = m[1]; m[1] = m[0]; m[0] = page_of(s);
        end else if (ae && rt) begin
            m[0] = m[1]; m[1] = m[2];
        end else if (we && ws != 2'd3) begin
            m[ws] = wd;
        end
        e.top = m[0]; e.mid = m[1]; e.bot = m[2]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(string tag);
        cyc(0, 1, 0, 4'd0, 0, 0, 2'd0, 8'h00, tag);
    endtask

    // Monitor: after each rising edge, compare all levels through the read port.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R11 page_sel"}, page_sel, e.top);
                sw_rsel = 2'd0; #0.5; check({e.tag, " R8 top"}, sw_rdata, e.top);
                sw_rsel = 2'd1; #0.5; check({e.tag, " R8 mid"}, sw_rdata, e.mid);
                sw_rsel = 2'd2; #0.5; check({e.tag, " R8 bot"}, sw_rdata, e.bot);
                sw_rsel = 2'd3; #0.5; check({e.tag, " R8 sel3"}, sw_rdata, 8'h00);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(1, 0, 0, 4'd0, 0, 0, 2'd0, 8'h00, "R1 reset");
        cyc(1, 1, 1, 4'd7, 0, 1, 2'd1, 8'hEE, "R1 reset overrides");
        // R7: load distinct values
        cyc(0, 1, 0, 4'd0, 0, 1, 2'd0, 8'h0F, "R7 wr top");
        cyc(0, 1, 0, 4'd0, 0, 1, 2'd1, 8'h3C, "R7 wr mid");
        cyc(0, 1, 0, 4'd0, 0, 1, 2'd2, 8'hA5, "R7 wr bot");
        cyc(0, 1, 0, 4'd0, 0, 1, 2'd3, 8'h99, "R7 sel3 ignored");
        // R2/R3: push drops written bottom
        cyc(0, 1, 1, 4'd0, 0, 0, 2'd0, 8'h00, "R2 R3 push src0");
        // R4: nested push
        cyc(0, 1, 1, 4'd5, 0, 0, 2'd0, 8'h00, "R4 nested push src5");
        // R5: pops
        cyc(0, 1, 0, 4'd0, 1, 0, 2'd0, 8'h00, "R5 pop1");
        cyc(0, 1, 0, 4'd0, 1, 0, 2'd0, 8'h00, "R5 pop2");
        // R6: disabled
        cyc(0, 0, 1, 4'd9, 0, 0, 2'd0, 8'h00, "R6 take disabled");
        cyc(0, 0, 0, 4'd0, 1, 0, 2'd0, 8'h00, "R6 ret disabled");
        cyc(0, 0, 1, 4'd3, 1, 1, 2'd2, 8'h44, "R6 disabled write goes");
        // R9: hardware wins over write
        cyc(0, 1, 1, 4'd2, 0, 1, 2'd0, 8'h77, "R9 push vs write");
        cyc(0, 1, 0, 4'd0, 1, 1, 2'd2, 8'h66, "R9 pop vs write");
        // R10: take and return together
        cyc(0, 1, 1, 4'd12, 1, 0, 2'd0, 8'h00, "R10 take+ret");
        // R3: software-written bottom lost
        cyc(0, 1, 0, 4'd0, 0, 1, 2'd2, 8'h5A, "R7 wr bot again");
        cyc(0, 1, 1, 4'd1, 0, 0, 2'd0, 8'h00, "R3 bottom lost");
        // R2: every source
        for (int s = 0; s < 16; s++) begin
            cyc(0, 1, 1, 4'(s), 0, 0, 2'd0, 8'h00, "R2 table sweep");
        end
        idle("R11 idle");
        cyc(1, 1, 0, 4'd0, 0, 0, 2'd0, 8'h00, "R1 reset again");
        idle("R1 after reset");
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule